// File: doc/BRIEF.md
# Audio serial clock divider

This block derives the clocks of an audio serial port from a single kernel clock. A linear prescaler divides the kernel clock by a ratio N = 2×DIV + ODD, so odd ratios are possible. The divided clock is used in one of two ways. It can be sent out as a master clock, with the bit clock taken from it by a further fixed division. Otherwise the master clock stays off and the divided clock serves directly as the bit clock. A frame strobe is generated in step with the bit clock. In two-channel (I2S) framing it is a word select at half duty over the frame. In PCM framing it is a one-bit-wide sync pulse at the start of each frame.

The configuration (divider, odd bit, master-clock enable, channel width and framing) is sampled only while the block is disabled. Enabling the block starts every counter from zero. An illegal ratio (N below 2) raises an error flag and keeps all clocks low. Every output comes straight from a flop clocked by the kernel clock, so the outputs cannot glitch.

Top module: `aud_clkgen`

## Requirements
- R1: While reset is held and after its release, mclk, bclk and ws are low and cfg_err is high, because the reset configuration (DIV=0, ODD=0) is illegal.
- R2: The ratio is N = 2×div_in + odd_in. When N < 2 is loaded, cfg_err is 1 and mclk, bclk and ws stay low even while en is high. When N ≥ 2 is loaded, cfg_err is 0.
- R3: With mck_en=0, mclk stays low and bclk has a period of N kernel cycles. bclk is high for the first ceil(N/2) cycles of each period, so for odd N the high phase is one cycle longer than the low phase.
- R4: With mck_en=1, mclk has a period of N kernel cycles with the high/low split of R3. bclk has a period of M×N cycles, where M=8 for chlen=0 and M=4 for chlen=1. bclk is high for the first M/2 master-clock periods.
- R5: With pcm_sel=0 (I2S), a frame is 32×(chlen+1) bit periods long. ws is low for the first half of the frame and high for the second half.
- R6: With pcm_sel=1 (PCM), a frame is 16×(chlen+1) bit periods long. ws is high during the first bit period of each frame and low otherwise.
- R7: Configuration inputs are captured on each kernel edge at which en is low. Changes made while en is high have no effect until the block has been disabled for at least one edge.
- R8: Outputs are registered. After the first edge that samples en high, all counters start at phase zero: bclk (or mclk) is high and the frame starts at bit 0. After an edge that samples en low, mclk, bclk and ws are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; configuration is captured while low |
| div_in | input | DIV_W | Linear divider value DIV |
| odd_in | input | 1 | Odd-adjust bit added to 2×DIV |
| mck_en | input | 1 | 1: output a master clock and derive bclk from it |
| chlen | input | 1 | Channel width: 0 = 16-bit, 1 = 32-bit |
| pcm_sel | input | 1 | Framing: 0 = I2S word select, 1 = PCM frame sync |
| mclk | output | 1 | Master clock (low when mck_en=0) |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select or frame sync strobe |
| cfg_err | output | 1 | Loaded ratio is below 2 |

## Verification
Each output level is due one cycle after the rising edge that sampled the counter state and en. cfg_err and the captured configuration are due one edge after a cycle with en low. The bench model advances its own phase index at every rising edge and uses the shadow configuration it captured at edges where en was low. It computes the expected mclk, bclk, ws and cfg_err from the period formulas. The DUT outputs are compared with the model at the following falling edge, where both are stable. The scenarios cover odd and even ratios, both channel widths, both framing modes, master clock on and off, illegal ratios, configuration changes while running, and a restart in the middle of a period.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_PCM = 1'b1
    } fmt_e;

    typedef struct packed {
        logic mck_on;
        logic wide;
        fmt_e fmt;
    } mode_t;

    localparam int RATIO_W = 4;
    localparam int MCNT_W  = RATIO_W - 1;
    localparam int FRAME_W = 7;
    localparam int BCNT_W  = FRAME_W - 1;

    function automatic logic [RATIO_W-1:0] mclk_ratio(input logic wide);
        return wide ? RATIO_W'(4) : RATIO_W'(8);
    endfunction

    function automatic logic [FRAME_W-1:0] frame_bits(input fmt_e fmt, input logic wide);
        logic [FRAME_W-1:0] base;
        base = (fmt == FMT_PCM) ? FRAME_W'(16) : FRAME_W'(32);
        return wide ? (base << 1) : base;
    endfunction

endpackage

// File: rtl/aud_clkgen_cfg.sv
module aud_clkgen_cfg
    import aud_clkgen_pkg::*;
#(
    parameter int DIV_W = 8,
    localparam int N_W = DIV_W + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [DIV_W-1:0] div_in,
    input  logic           odd_in,
    input  mode_t          mode_in,
    output logic [N_W-1:0] ratio_q,
    output mode_t          mode_q,
    output logic           err_q
);

    logic [N_W-1:0] ratio_in;
    assign ratio_in = {div_in, 1'b0} + N_W'(odd_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= '0;
            mode_q  <= '0;
            err_q   <= 1'b1;
        end else if (!en) begin
            ratio_q <= ratio_in;
            mode_q  <= mode_in;
            err_q   <= (ratio_in < N_W'(2));
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst)) |-> ($stable(ratio_q) && $stable(mode_q) && $stable(err_q))) // R7
        else $error("config changed while enabled");

    AST_ERR_MATCH: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && !$past(rst)) |-> (err_q == (ratio_q < N_W'(2)))) // R2
        else $error("error flag disagrees with ratio");

endmodule

// File: rtl/aud_clkgen_presc.sv
module aud_clkgen_presc #(
    parameter int N_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [N_W-1:0] ratio,
    output logic           hi,
    output logic           wrap
);

    logic [N_W-1:0] pcnt;
    logic [N_W:0]   half;

    assign half = ({1'b0, ratio} + (N_W+1)'(1)) >> 1;
    assign hi   = ({1'b0, pcnt} < half);
    assign wrap = run && (pcnt == ratio - N_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
        end else if (wrap) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + N_W'(1);
        end
    end

    AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (pcnt < ratio)) // R2
        else $error("prescaler count out of range");

endmodule

// File: rtl/aud_clkgen_framer.sv
module aud_clkgen_framer
    import aud_clkgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  mode_t mode,
    input  logic  hi,
    input  logic  wrap,
    output logic  mclk_q,
    output logic  bclk_q,
    output logic  ws_q
);

    logic [MCNT_W-1:0]  mcnt;
    logic [BCNT_W-1:0]  bitcnt;
    logic [RATIO_W-1:0] ratio;
    logic [FRAME_W-1:0] fbits;
    logic               m_last;
    logic               btick;
    logic               b_last;
    logic               mclk_d, bclk_d, ws_d;

    assign ratio  = mclk_ratio(mode.wide);
    assign fbits  = frame_bits(mode.fmt, mode.wide);
    assign m_last = ({1'b0, mcnt} == ratio - RATIO_W'(1));
    assign btick  = mode.mck_on ? (wrap && m_last) : wrap;
    assign b_last = ({1'b0, bitcnt} == fbits - FRAME_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            mcnt   <= '0;
            bitcnt <= '0;
        end else begin
            if (wrap) begin
                mcnt <= m_last ? '0 : mcnt + MCNT_W'(1);
            end
            if (btick) begin
                bitcnt <= b_last ? '0 : bitcnt + BCNT_W'(1);
            end
        end
    end

    always_comb begin
        mclk_d = mode.mck_on && hi;
        bclk_d = mode.mck_on ? ({1'b0, mcnt} < (ratio >> 1)) : hi;
        if (mode.fmt == FMT_PCM) begin
            ws_d = (bitcnt == '0);
        end else begin
            ws_d = ({1'b0, bitcnt} >= (fbits >> 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            mclk_q <= 1'b0;
            bclk_q <= 1'b0;
            ws_q   <= 1'b0;
        end else begin
            mclk_q <= mclk_d;
            bclk_q <= bclk_d;
            ws_q   <= ws_d;
        end
    end

    AST_MCLK_GATED: assert property (@(posedge clk) disable iff (rst)
        !mode.mck_on |-> !mclk_q) // R3
        else $error("master clock active while disabled");

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (mcnt == '0 && bitcnt == '0)) // R8
        else $error("counters not at zero on enable");

endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
    import aud_clkgen_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_in,
    input  logic             odd_in,
    input  logic             mck_en,
    input  logic             chlen,
    input  logic             pcm_sel,
    output logic             mclk,
    output logic             bclk,
    output logic             ws,
    output logic             cfg_err
);

    localparam int N_W = DIV_W + 1;

    mode_t          mode_in, mode_q;
    logic [N_W-1:0] ratio_q;
    logic           err_q;
    logic           run;
    logic           hi, wrap;

    assign mode_in = '{mck_on: mck_en, wide: chlen, fmt: fmt_e'(pcm_sel)};
    assign run     = en && !err_q;
    assign cfg_err = err_q;

    aud_clkgen_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .div_in  (div_in),
        .odd_in  (odd_in),
        .mode_in (mode_in),
        .ratio_q (ratio_q),
        .mode_q  (mode_q),
        .err_q   (err_q)
    );

    aud_clkgen_presc #(.N_W(N_W)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .ratio (ratio_q),
        .hi    (hi),
        .wrap  (wrap)
    );

    aud_clkgen_framer u_framer (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .mode   (mode_q),
        .hi     (hi),
        .wrap   (wrap),
        .mclk_q (mclk),
        .bclk_q (bclk),
        .ws_q   (ws)
    );

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!mclk && !bclk && !ws)) // R2
        else $error("clocks running with illegal ratio");

    AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && !$past(rst)) |-> (!mclk && !bclk && !ws)) // R8
        else $error("outputs active after disable");

endmodule

// File: tb/aud_clkgen_tb.sv
`timescale 1ns/1ps
module aud_clkgen_tb;

    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic [DIV_W-1:0] div_in = '0;
    logic odd_in = 1'b0, mck_en = 1'b0, chlen = 1'b0, pcm_sel = 1'b0;
    logic mclk, bclk, ws, cfg_err;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit started = 0;

    always #4 clk = ~clk;

    aud_clkgen #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .div_in(div_in), .odd_in(odd_in),
        .mck_en(mck_en), .chlen(chlen), .pcm_sel(pcm_sel),
        .mclk(mclk), .bclk(bclk), .ws(ws), .cfg_err(cfg_err)
    );

    // behavioural reference model
    int s_div; bit s_odd, s_mck, s_ch, s_pcm;
    int mj;
    bit e_mclk, e_bclk, e_ws, e_err;

    always @(posedge clk) begin
        int n, r, fb, b;
        bit h;
        started = 1;
        if (rst) begin
            s_div = 0; s_odd = 0; s_mck = 0; s_ch = 0; s_pcm = 0;
            mj = 0; e_mclk = 0; e_bclk = 0; e_ws = 0; e_err = 1;
        end else begin
            n = 2 * s_div + s_odd;
            if (en && n >= 2) begin
                r  = s_ch ? 4 : 8;
                fb = (s_pcm ? 16 : 32) * (s_ch + 1);
                h  = (mj % n) < ((n + 1) / 2);
                if (!s_mck) begin
                    e_mclk = 0; e_bclk = h; b = (mj / n) % fb;
                end else begin
                    e_mclk = h; e_bclk = ((mj / n) % r) < (r / 2); b = (mj / (n * r)) % fb;
                end
                e_ws = s_pcm ? (b == 0) : (b >= fb / 2);
                mj++;
            end else begin
                mj = 0; e_mclk = 0; e_bclk = 0; e_ws = 0;
            end
            if (!en) begin
                s_div = int'(div_in); s_odd = odd_in; s_mck = mck_en; s_ch = chlen; s_pcm = pcm_sel;
                e_err = (2 * s_div + s_odd) < 2;
            end
        end
    end

    task automatic chk(string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            if (errors < 25)
                $display("FAIL %s %s act=%b exp=%b t=%0t", cur_req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("mclk", mclk, e_mclk);
            chk("bclk", bclk, e_bclk);
            chk("ws", ws, e_ws);
            chk("cfg_err", cfg_err, e_err);
        end
    end

    task automatic load(int d, bit o, bit m, bit c, bit p);
        @(negedge clk);
        en = 0; div_in = DIV_W'(d); odd_in = o; mck_en = m; chlen = c; pcm_sel = p;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_for(int k);
        @(negedge clk);
        en = 1;
        repeat (k) @(negedge clk);
        en = 0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);

        cur_req = "R2";                 // illegal ratios N=1 and N=0
        load(0, 1, 0, 0, 0); run_for(40);
        load(0, 0, 1, 1, 1); run_for(40);

        cur_req = "R3";                 // bit clock direct, odd ratio N=3, I2S 16-bit
        load(1, 1, 0, 0, 0); run_for(250);

        cur_req = "R5";                 // N=4, I2S 32-bit channel
        load(2, 0, 0, 1, 0); run_for(600);

        cur_req = "R4";                 // master clock on, N=3, M=8
        load(1, 1, 1, 0, 0); run_for(1700);

        cur_req = "R6";                 // PCM with master clock, N=5, 32-bit, M=4
        load(2, 1, 1, 1, 1); run_for(1400);
        load(1, 0, 0, 0, 1); run_for(120);  // PCM direct, N=2, 16-bit frame

        cur_req = "R7";                 // changes while enabled ignored
        load(1, 1, 0, 0, 0);
        @(negedge clk); en = 1;
        repeat (100) @(negedge clk);
        div_in = 8'd0; odd_in = 1; mck_en = 1; pcm_sel = 1; chlen = 1;
        repeat (300) @(negedge clk);
        en = 0;
        load(3, 0, 1, 1, 1); run_for(600);

        cur_req = "R8";                 // restart mid-period
        load(3, 1, 0, 0, 1);
        @(negedge clk); en = 1;
        repeat (37) @(negedge clk);
        en = 0;
        @(negedge clk); en = 1;
        repeat (300) @(negedge clk);
        en = 0;
        repeat (4) @(negedge clk);

        summary();
        $finish;
    end

endmodule